// File: doc/BRIEF.md
# Logarithmic Bidirectional Barrel Shifter

This block is a purely combinational word shifter for a datapath functional unit. A shift of any distance from 0 to W-1 is broken into its binary digits. A cascade of log2(W) stages then applies those digits one after another: the stage for amount bit k either passes its word through unchanged or moves it by 2^k places. Every bit of every stage is the same four-way selector. It chooses between the unshifted bit, the neighbour 2^k places to one side, the neighbour 2^k places to the other side, and an edge fill value.

The fill value at the word edges depends on the shift type, so one network serves all the cases. A logical shift brings in zeros. An arithmetic right shift copies the sign bit, which gives signed division by a power of two. A rotation wraps around, so bits that leave one end of the word enter at the other end. An output enable places the result on the shared result bus and drives zeros when the unit is not selected.

Top module: `barrel_shift`

## Requirements
- R1: When `oe` is 0, `dout` is all zeros, whatever the other inputs are.
- R2: When `amt` is 0 and `oe` is 1, `dout` equals `din` for every value of `kind` and `dir`.
- R3: A logical left shift (`kind`=00, `dir`=0) gives `din` multiplied by 2^`amt`, taken modulo 2^W. Zeros enter at bit 0.
- R4: A logical right shift (`kind`=00, `dir`=1) gives `din` divided by 2^`amt` as an unsigned value. Zeros enter at bit W-1.
- R5: An arithmetic right shift (`kind`=01, `dir`=1) copies the original bit W-1 into every vacated upper position. This gives floor division of the signed value by 2^`amt`.
- R6: An arithmetic left shift (`kind`=01, `dir`=0) gives the same result as a logical left shift.
- R7: A left rotate (`kind`=10, `dir`=0) moves every bit i to position (i+`amt`) mod W.
- R8: A right rotate (`kind`=10, `dir`=1) moves every bit i to position (i-`amt`) mod W.
- R9: The reserved type code `kind`=11 behaves exactly like logical shifting in both directions.
- R10: Each set bit k of `amt` adds 2^k to the shift distance. This holds for amounts with several bits set, including the largest amount W-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din  | input  | W      | Operand word |
| amt  | input  | log2(W) | Shift distance |
| dir  | input  | 1      | 0 = toward bit W-1 (left), 1 = toward bit 0 (right) |
| kind | input  | 2      | 00 logical, 01 arithmetic, 10 rotate, 11 treated as logical |
| oe   | input  | 1      | Drives the result onto `dout` when 1 |
| dout | output | W      | Shifted result, or zero when not enabled |

## Verification
Two functions meet in one evaluation when several amount bits are set together. In that case the edge fill of one stage becomes data that a later stage moves again. A sign bit copied in by the 1-place stage must therefore be copied again by the 4-place and 16-place stages. Likewise, a bit that wraps around in a rotate must wrap a second time correctly. The bench provokes this with amounts such as 5, 21 and 31 applied to negative operands and to single-bit patterns. Each result is compared with a reference that shifts one place at a time, a method that has no notion of stages.

// File: rtl/barrel_shift.sv
module barrel_shift #(
  parameter int W = 32,
  localparam int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          dir,
  input  logic [1:0]    kind,
  input  logic          oe,
  output logic [W-1:0]  dout
);

  logic [SW:0][W-1:0] stg;
  logic rot, arith;

  assign rot   = (kind == 2'b10);
  assign arith = (kind == 2'b01);
  assign stg[0] = din;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int K = 1 << k;
    for (genvar i = 0; i < W; i++) begin : g_bit
      logic lft, rgt;
      if (i >= K) begin : g_lin
        assign lft = stg[k][i-K];
      end else begin : g_ledge
        assign lft = rot ? stg[k][i-K+W] : 1'b0;
      end
      if (i + K < W) begin : g_rin
        assign rgt = stg[k][i+K];
      end else begin : g_redge
        assign rgt = rot ? stg[k][i+K-W] : (arith & stg[k][W-1]);
      end
      assign stg[k+1][i] = !amt[k] ? stg[k][i] : (dir ? rgt : lft);
    end
  end

  assign dout = oe ? stg[SW] : '0;

  always_comb begin
    // R1
    if (!oe) begin
      oe_gate_chk: assert (dout == '0);
    end
    // R2
    if (oe && amt == '0) begin
      zero_amt_chk: assert (dout == din);
    end
    // R7
    if (oe && kind == 2'b10) begin
      rot_keep_chk: assert ($countones(dout) == $countones(din));
    end
    // R5
    if (oe && kind == 2'b01 && dir) begin
      sign_keep_chk: assert (dout[W-1] == din[W-1]);
    end
    // R4
    if (oe && kind == 2'b00 && dir && amt != '0) begin
      lsr_top_chk: assert (dout[W-1] == 1'b0);
    end
    // R3
    if (oe && kind != 2'b10 && !dir && amt != '0) begin
      lsl_low_chk: assert (dout[0] == 1'b0);
    end
  end

endmodule

// File: tb/tb_barrel_shift.sv
module tb_barrel_shift;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] din = '0;
  logic [4:0]   amt = '0;
  logic         dir = 1'b0;
  logic [1:0]   kind = 2'b00;
  logic         oe = 1'b0;
  logic [W-1:0] dout;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  barrel_shift #(.W(W)) dut (
    .din(din), .amt(amt), .dir(dir), .kind(kind), .oe(oe), .dout(dout)
  );

  function automatic logic [W-1:0] model(logic [W-1:0] d, int n, logic r,
                                         logic [1:0] t, logic en);
    logic [W-1:0] v = d;
    for (int s = 0; s < n; s++) begin
      if (t == 2'b10) v = r ? {v[0], v[W-1:1]} : {v[W-2:0], v[W-1]};
      else if (r)     v = {(t == 2'b01) ? v[W-1] : 1'b0, v[W-1:1]};
      else            v = {v[W-2:0], 1'b0};
    end
    return en ? v : '0;
  endfunction

  function automatic string tag(int n, logic r, logic [1:0] t, logic en);
    if (!en) return "R1";
    if (n == 0) return "R2";
    if (t == 2'b11) return "R9";
    if (t == 2'b10) return r ? "R8" : "R7";
    if (t == 2'b01) return r ? "R5" : "R6";
    return r ? "R4" : "R3";
  endfunction

  task automatic apply(logic [W-1:0] d, int n, logic r, logic [1:0] t,
                       logic en, string req);
    logic [W-1:0] exp;
    @(posedge clk);
    din = d; amt = 5'(n); dir = r; kind = t; oe = en;
    exp = model(d, n, r, t, en);
    @(negedge clk);
    n_cmp++;
    if (dout !== exp) begin
      n_bad++;
      $display("FAIL %s din=%h amt=%0d dir=%0b kind=%b oe=%0b got=%h exp=%h",
               req, d, n, r, t, en, dout, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1 reset state and gating
    apply(32'h0, 0, 0, 2'b00, 0, "R1");
    apply(32'hDEADBEEF, 7, 1, 2'b10, 0, "R1");
    // R2 zero amount, every type and direction
    for (int t = 0; t < 4; t++)
      for (int r = 0; r < 2; r++)
        apply(32'hA5C3_0F96, 0, r[0], t[1:0], 1, "R2");
    apply(32'h0000_0001, 1, 0, 2'b00, 1, "R3");
    apply(32'hFFFF_FFFF, 31, 0, 2'b00, 1, "R3");
    apply(32'h8000_0000, 31, 1, 2'b00, 1, "R4");
    apply(32'hF000_000F, 4, 1, 2'b00, 1, "R4");
    apply(32'h8000_0000, 31, 1, 2'b01, 1, "R5");
    apply(32'hFFFF_FF00, 5, 1, 2'b01, 1, "R5");
    apply(32'h7FFF_FFFF, 21, 1, 2'b01, 1, "R5");
    apply(32'h8000_0001, 3, 0, 2'b01, 1, "R6");
    apply(32'h8000_0001, 1, 0, 2'b10, 1, "R7");
    apply(32'h0000_0003, 31, 0, 2'b10, 1, "R7");
    apply(32'h0000_0001, 1, 1, 2'b10, 1, "R8");
    apply(32'h1234_5678, 21, 1, 2'b10, 1, "R8");
    apply(32'hF0F0_1234, 9, 0, 2'b11, 1, "R9");
    apply(32'hF0F0_1234, 9, 1, 2'b11, 1, "R9");
    // R10 each amount bit alone and combined
    for (int k = 0; k < 5; k++) begin
      apply(32'h8000_0001, 1 << k, 1, 2'b10, 1, "R10");
      apply(32'h9000_0001, 1 << k, 1, 2'b01, 1, "R10");
    end
    apply(32'hC000_0000, 31, 1, 2'b01, 1, "R10");
    apply(32'h0000_0001, 31, 0, 2'b10, 1, "R10");
    for (int j = 0; j < 600; j++) begin
      logic [W-1:0] d = $urandom();
      int n = $urandom_range(0, 31);
      logic r = 1'($urandom());
      logic [1:0] t = 2'($urandom());
      logic en = ($urandom_range(0, 7) != 0);
      apply(d, n, r, t, en, tag(n, r, t, en));
    end
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule